// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Dead Time

This block drives the two gate enables of a half-bridge from a digital ramp counter instead of an RC timing network. The ramp climbs from zero to a lower threshold, then runs back and forth between that threshold and one twice as high. The low-side enable is active while the ramp rises and the high-side enable while it falls, which gives a 50% duty cycle. Each enable comes on only after a dead-time interval, measured from the start of its half-cycle, so the two switches never conduct together.

Operation is gated by a supply qualifier with hysteresis, an external shutdown request and a configuration check. Any of these stops the ramp and returns it to zero. The next start therefore climbs to the lower threshold again, and the first pulse lands on the low side so the bootstrap capacitor charges before the high side fires. The bootstrap-charge enable follows the low-side enable exactly. All controls are plain level signals sampled on the clock.

Top module: `hb_sequencer`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted and in the cycle after it is released, lo, ho and boot_en are 0. After reset the block waits in lockout until the supply qualifies.
- R2: The supply qualifies when supply_code >= UV_ON_CODE (default 176) and disqualifies only when supply_code < UV_OFF_CODE (default 144). A code inside the band keeps the previous qualification, whether the block is running or locked out.
- R3: While the supply is not qualified, lo, ho and boot_en are 0. They read 0 at the first sample after the clock edge that sees the low code.
- R4: With half count H and active dead count D, the ramp climbs from 0 for H cycles and then alternates between a rising and a falling half-cycle of H cycles each. The period is 2H. lo is high for the last H-D cycles of each rising half and ho for the last H-D cycles of each falling half. The first lo pulse starts H+D cycles after the starting clock edge.
- R5: Both outputs are 0 for exactly D cycles between lo falling and ho rising, and for exactly D cycles between ho falling and lo rising.
- R6: After every start or restart, the first output pulse is on lo. ho stays 0 until lo has pulsed.
- R7: boot_en equals lo in every cycle.
- R8: While shutdown_req is 1, lo, ho and boot_en are 0 from the first sample after the edge that sees it. After release the ramp restarts from 0, and the first lo pulse starts H+D cycles after the release edge.
- R9: dead_sel = 0 selects dead_long as D and dead_sel = 1 selects dead_short.
- R10: A configuration with D >= half_period is rejected: the ramp is held at zero and lo and ho stay 0.
- R11: lo and ho are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_code | input | SUP_W (8) | Digitized supply level |
| shutdown_req | input | 1 | Stop request; holds the outputs off |
| half_period | input | CNT_W (16) | Ramp half-period H in cycles |
| dead_long | input | CNT_W (16) | Longer dead-time count |
| dead_short | input | CNT_W (16) | Shorter dead-time count |
| dead_sel | input | 1 | 0 selects dead_long, 1 selects dead_short |
| lo | output | 1 | Low-side gate enable |
| ho | output | 1 | High-side gate enable |
| boot_en | output | 1 | Bootstrap-charge enable |

## Verification
Two situations are hard to reach from the ports. The first is a shutdown that lands in the middle of a live low-side pulse. The second is a supply code inside the hysteresis band while the bridge is already switching. For the first, the bench waits until lo reads high, asserts shutdown on that same negative edge, and checks that the outputs are off at the very next sample and that the restart delay is a full climb plus dead time. For the second, the bench moves the running block into the band and counts low-side pulses. It then moves the code below the band and back into it, and checks that the band alone does not restart the block.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLIMB = 2'd1,
    PH_RISE  = 2'd2,
    PH_FALL  = 2'd3
  } phase_t;
endpackage

// File: rtl/hb_uvlo.sv
module hb_uvlo #(
  parameter int SUP_W = 8,
  parameter int UV_ON_CODE = 176,
  parameter int UV_OFF_CODE = 144
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUP_W-1:0] supply_code,
  output logic             ok_next,
  output logic             ok
);
  localparam logic [SUP_W-1:0] ON_LVL  = SUP_W'(UV_ON_CODE);
  localparam logic [SUP_W-1:0] OFF_LVL = SUP_W'(UV_OFF_CODE);

  always_comb begin
    if (ok) ok_next = (supply_code >= OFF_LVL);
    else    ok_next = (supply_code >= ON_LVL);
  end

  always_ff @(posedge clk) begin
    if (rst) ok <= 1'b0;
    else     ok <= ok_next;
  end

  // R2: below the turn-on level a locked block stays locked
  assert_stay_locked_R2: assert property (@(posedge clk) disable iff (rst)
    (!ok && supply_code < ON_LVL) |=> !ok);
  // R2: at or above the turn-off level a running block stays qualified
  assert_stay_qualified_R2: assert property (@(posedge clk) disable iff (rst)
    (ok && supply_code >= OFF_LVL) |=> ok);
endmodule

// File: rtl/hb_ramp.sv
module hb_ramp
  import hb_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] half_period,
  output phase_t           phase
);
  localparam int RW = CNT_W + 2;
  localparam logic [RW-1:0] RONE = RW'(1);

  logic [RW-1:0] ramp, lo_th, hi_th, ramp_up;

  assign lo_th   = {2'b00, half_period};
  assign hi_th   = {1'b0, half_period, 1'b0};
  assign ramp_up = ramp + RONE;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= PH_IDLE;
      ramp  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_CLIMB;
          ramp  <= '0;
        end
        PH_CLIMB: begin
          if (ramp_up >= lo_th) begin
            phase <= PH_RISE;
            ramp  <= lo_th;
          end else begin
            ramp <= ramp_up;
          end
        end
        PH_RISE: begin
          if (ramp_up >= hi_th) begin
            phase <= PH_FALL;
            ramp  <= hi_th;
          end else begin
            ramp <= ramp_up;
          end
        end
        default: begin
          if (ramp <= lo_th + RONE) begin
            phase <= PH_RISE;
            ramp  <= lo_th;
          end else begin
            ramp <= ramp - RONE;
          end
        end
      endcase
    end
  end

  // R6: the climb never hands over to the falling half, so lo always fires first
  assert_climb_to_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CLIMB && run) |=> (phase == PH_CLIMB || phase == PH_RISE));
  // R8: any stop request returns the ramp to idle at the next edge
  assert_stop_idles_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase == PH_IDLE));
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
  import hb_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_t           phase,
  input  logic [CNT_W-1:0] dead,
  output logic             lo,
  output logic             ho
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t           phase_q;
  logic [CNT_W-1:0] held_cnt, elapsed;
  logic             fresh;

  assign fresh   = (phase != phase_q);
  assign elapsed = fresh ? '0 : held_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      held_cnt <= '0;
    end else begin
      phase_q <= phase;
      if (fresh)                held_cnt <= ONE;
      else if (held_cnt != '1)  held_cnt <= held_cnt + ONE;
    end
  end

  assign lo = (phase == PH_RISE) && (elapsed >= dead);
  assign ho = (phase == PH_FALL) && (elapsed >= dead);

  // R5: with a non-zero dead time, the cycle before ho rises has lo low
  assert_gap_before_ho_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(ho) && dead != '0) |-> !$past(lo));
  // R5: with a non-zero dead time, the cycle before lo rises has ho low
  assert_gap_before_lo_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(lo) && dead != '0) |-> !$past(ho));
endmodule

// File: rtl/hb_sequencer.sv
module hb_sequencer
  import hb_seq_pkg::*;
#(
  parameter int SUP_W = 8,
  parameter int CNT_W = 16,
  parameter int UV_ON_CODE = 176,
  parameter int UV_OFF_CODE = 144
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUP_W-1:0] supply_code,
  input  logic             shutdown_req,
  input  logic [CNT_W-1:0] half_period,
  input  logic [CNT_W-1:0] dead_long,
  input  logic [CNT_W-1:0] dead_short,
  input  logic             dead_sel,
  output logic             lo,
  output logic             ho,
  output logic             boot_en
);
  logic             ok_next, supply_ok, cfg_ok, run;
  logic [CNT_W-1:0] dead;
  phase_t           phase;

  assign dead   = dead_sel ? dead_short : dead_long;
  assign cfg_ok = (dead < half_period);
  assign run    = ok_next && !shutdown_req && cfg_ok;

  hb_uvlo #(
    .SUP_W(SUP_W), .UV_ON_CODE(UV_ON_CODE), .UV_OFF_CODE(UV_OFF_CODE)
  ) u_uvlo (
    .clk(clk), .rst(rst), .supply_code(supply_code),
    .ok_next(ok_next), .ok(supply_ok)
  );

  hb_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk(clk), .rst(rst), .run(run),
    .half_period(half_period), .phase(phase)
  );

  hb_deadtime #(.CNT_W(CNT_W)) u_dead (
    .clk(clk), .rst(rst), .phase(phase), .dead(dead),
    .lo(lo), .ho(ho)
  );

  assign boot_en = lo;

  // R11: the two gate enables never overlap
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(lo && ho));
  // R3: an unqualified supply keeps both gates off
  assert_lockout_off_R3: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |-> (!lo && !ho));
  // R8: a shutdown request turns everything off at the next edge
  assert_shutdown_off_R8: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |=> (!lo && !ho && !boot_en));
  // R10: a rejected configuration keeps both gates off
  assert_badcfg_off_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> (!lo && !ho));
endmodule

// File: tb/hb_sequencer_test.sv
module hb_sequencer_test;
  localparam int H  = 20;
  localparam int DL = 6;
  localparam int DS = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  supply_code = 8'd0;
  logic        shutdown_req = 1'b0;
  logic [15:0] half_period = 16'(H);
  logic [15:0] dead_long = 16'(DL);
  logic [15:0] dead_short = 16'(DS);
  logic        dead_sel = 1'b0;
  logic        lo, ho, boot_en;

  int checks = 0;
  int failures = 0;
  int boot_bad = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_sequencer uut (
    .clk(clk), .rst(rst), .supply_code(supply_code), .shutdown_req(shutdown_req),
    .half_period(half_period), .dead_long(dead_long), .dead_short(dead_short),
    .dead_sel(dead_sel), .lo(lo), .ho(ho), .boot_en(boot_en)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (boot_en !== lo) boot_bad++;
      if (lo && ho) overlap++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count consecutive samples with the given output pattern; ends on the first other sample
  task automatic run_len(input logic elo, input logic eho, output int n);
    n = 0;
    while (lo == elo && ho == eho && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_active(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      if (lo || ho || boot_en) n++;
      @(negedge clk);
    end
  endtask

  // starting at the first sample after a start edge, check the R4/R5/R6 sequence
  task automatic check_sequence(input string tag, input int d);
    int n;
    run_len(1'b0, 1'b0, n);
    check({tag, " R4 first lo delay"}, n, H + d);
    check({tag, " R6 first pulse on lo"}, int'(lo), 1);
    run_len(1'b1, 1'b0, n);
    check({tag, " R4 lo width"}, n, H - d);
    run_len(1'b0, 1'b0, n);
    check({tag, " R5 gap lo->ho"}, n, d);
    run_len(1'b0, 1'b1, n);
    check({tag, " R4 ho width"}, n, H - d);
    run_len(1'b0, 1'b0, n);
    check({tag, " R5 gap ho->lo"}, n, d);
    run_len(1'b1, 1'b0, n);
    check({tag, " R4 second lo width"}, n, H - d);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 lo after reset", int'(lo), 0);
    check("R1 ho after reset", int'(ho), 0);
    check("R1 boot_en after reset", int'(boot_en), 0);
  endtask

  task automatic t_lockout;
    int n;
    supply_code = 8'd175;
    @(negedge clk);
    count_active(60, n);
    check("R2 R3 below turn-on stays locked", n, 0);
  endtask

  task automatic t_startup;
    supply_code = 8'd200;
    @(negedge clk);
    check_sequence("startup", DL);
  endtask

  task automatic t_hysteresis;
    int n, rises;
    logic prev;
    supply_code = 8'd150;
    rises = 0;
    prev = lo;
    for (int i = 0; i < 2 * 2 * H; i++) begin
      @(negedge clk);
      if (lo && !prev) rises++;
      prev = lo;
    end
    check("R2 in-band keeps running (lo pulses)", rises, 2);
    supply_code = 8'd100;
    @(negedge clk);
    check("R3 outputs off after dropout", int'(lo || ho || boot_en), 0);
    count_active(3 * H, n);
    check("R3 stays off in dropout", n, 0);
    supply_code = 8'd150;
    @(negedge clk);
    count_active(3 * H, n);
    check("R2 in-band does not restart", n, 0);
  endtask

  task automatic t_shutdown;
    int n;
    int guard;
    supply_code = 8'd200;
    @(negedge clk);
    guard = 0;
    while (!lo && guard < 1000) begin
      guard++;
      @(negedge clk);
    end
    check("R8 lo reached before shutdown", int'(lo), 1);
    shutdown_req = 1'b1;
    @(negedge clk);
    check("R8 outputs off after shutdown", int'(lo || ho || boot_en), 0);
    count_active(50, n);
    check("R8 held off during shutdown", n, 0);
    shutdown_req = 1'b0;
    @(negedge clk);
    check_sequence("restart R8", DL);
  endtask

  task automatic t_short_dead;
    shutdown_req = 1'b1;
    @(negedge clk);
    dead_sel = 1'b1;
    @(negedge clk);
    shutdown_req = 1'b0;
    @(negedge clk);
    check_sequence("short dead R9", DS);
  endtask

  task automatic t_bad_config;
    int n;
    shutdown_req = 1'b1;
    @(negedge clk);
    dead_sel = 1'b0;
    dead_long = 16'(H);
    @(negedge clk);
    shutdown_req = 1'b0;
    @(negedge clk);
    count_active(5 * H, n);
    check("R10 dead equal to half rejected", n, 0);
    dead_long = 16'(H + 5);
    @(negedge clk);
    count_active(5 * H, n);
    check("R10 dead above half rejected", n, 0);
    dead_long = 16'(H - 1);
    @(negedge clk);
    run_len(1'b0, 1'b0, n);
    check("R10 R4 largest valid dead delay", n, H + H - 1);
    run_len(1'b1, 1'b0, n);
    check("R10 R4 largest valid dead lo width", n, 1);
  endtask

  initial begin
    t_reset();
    t_lockout();
    t_startup();
    t_hysteresis();
    t_shutdown();
    t_short_dead();
    t_bad_config();
    check("R7 boot_en follows lo", boot_bad, 0);
    check("R11 no overlap", overlap, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule